// File: doc/BRIEF.md
# Sparsified Dual-Bank Hit-Count Readout

This block serves one readout group of a photon-counting pixel array: 256 pixels, each delivering single-cycle hit pulses from its discriminator. Every pixel keeps two 5-bit hit counters. One counter bank accumulates hits while the other, frozen, bank is read out, so counting continues without interruption during readout.

A frame-swap command exchanges the roles of the two banks. It clears the bank that becomes active and records which pixels of the frozen bank hold a nonzero count. A lowest-index-first priority encoder then walks those pixels. Each one is sent on a single serial line as a fixed 16-bit word that carries the pixel address and its count. Pixels with no hits cost no output time. Each pixel takes 16 serial clocks, which is 160 ns at a 100 MHz line clock.

Top module: `hit_group_readout`

## Requirements
- R1: `hit_i` and `frame_swap_i` both pass through a single register stage. A hit pulse and a swap presented in the same cycle therefore reach the counters together.
- R2: Each pixel has two 5-bit counters. The active bank adds one for each registered hit pulse. The frozen bank holds its value until the next accepted swap, including during readout.
- R3: A counter saturates at 31. Further hits leave it at 31.
- R4: An accepted swap makes the frozen bank the active one and clears it. A hit that coincides with the swap loads it with 1 instead of 0. The bank that was active becomes frozen, and its nonzero pixels form the scan mask.
- R5: Only pixels whose frozen count is nonzero are reported, each exactly once per swap.
- R6: Reports leave in ascending pixel address order.
- R7: A report is 16 bits, one bit per clock, first bit first: a 1 start bit, then address bits 7..0, then count bits 4..0, then two 0 stop bits. Successive reports follow with no gap. The line is 0 when idle.
- R8: `busy_o` is high from the cycle after an accepted swap while any masked pixel remains or a report is still shifting. It stays low after a swap that finds no hit pixel.
- R9: A swap that reaches the register stage while `busy_o` is high is ignored: no bank change and no mask change. It sets `overrun_o`, which stays set until reset.
- R10: After reset, both banks are zero, bank 0 is active, and `ser_o`, `busy_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | 256 | One single-cycle hit pulse per pixel |
| frame_swap_i | input | 1 | Request to exchange counting and readout banks |
| ser_o | output | 1 | Serial report line |
| busy_o | output | 1 | Readout of the frozen bank in progress |
| overrun_o | output | 1 | Sticky flag: a swap was requested while busy |

## Verification
The first frame gives pixel p a total of p mod 37 hits. This covers zero-hit gaps, every count from 1 up past the saturation point, and the full address range in a dense pattern. The second frame is sparse, covering the extreme addresses, a hit that coincides with the swap, and a saturated pixel. Its hits are counted while the first frame is still being read out, and a swap requested during that readout is refused, so a lost or cleared count would show up. An empty frame checks that no output appears and that the busy flag stays low. A final all-pixels-once frame checks back-to-back reports across all 256 addresses.

// File: rtl/hgr_pkg.sv
package hgr_pkg;
    localparam logic START_BIT = 1'b1;
    localparam int   STOP_BITS = 2;

    function automatic int frame_len(input int aw, input int cw);
        return 1 + aw + cw + STOP_BITS;
    endfunction
endpackage

// File: rtl/hgr_pixel.sv
module hgr_pixel #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          swap_i,
    input  logic          sel_i,
    output logic [CW-1:0] act_cnt_o,
    output logic [CW-1:0] frz_cnt_o
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [1:0][CW-1:0] cnt;
    } pix_t;

    pix_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swap_i) begin
            st_d.cnt[~sel_i] = hit_i ? CW'(1) : '0;
        end else if (hit_i && st_q.cnt[sel_i] != CMAX) begin
            st_d.cnt[sel_i] = st_q.cnt[sel_i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cnt_o = st_q.cnt[sel_i];
    assign frz_cnt_o = st_q.cnt[~sel_i];

    // R3: a full counter stays full until the banks exchange
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_i && act_cnt_o == CMAX) |=> act_cnt_o == CMAX);
    // R2: the frozen bank is untouched between swaps
    a_r2_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(frz_cnt_o));
    // R4: the counting bank becomes the frozen one intact
    a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> frz_cnt_o == $past(act_cnt_o));
endmodule

// File: rtl/hgr_prio_enc.sv
module hgr_prio_enc #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [AW-1:0] idx_o,
    output logic          valid_o
);
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = AW'(i);
                valid_o = 1'b1;
            end
        end
    end

    // R6: the chosen index is a requesting one
    always_comb begin
        if (valid_o) a_r6_sel_set: assert (req_i[idx_o]);
    end
endmodule

// File: rtl/hgr_serializer.sv
module hgr_serializer
    import hgr_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avail_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] cnt_i,
    output logic          take_o,
    output logic          ser_o,
    output logic          on_o
);
    localparam int FW = frame_len(AW, CW);
    localparam int BW = $clog2(FW);

    typedef struct packed {
        logic [FW-1:0] shift;
        logic [BW-1:0] bits;
        logic          on;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        take_o = avail_i && (!st_q.on || st_q.bits == '0);
        if (take_o) begin
            st_d.shift = {START_BIT, addr_i, cnt_i, {STOP_BITS{1'b0}}};
            st_d.bits  = BW'(FW - 1);
            st_d.on    = 1'b1;
        end else if (st_q.on && st_q.bits != '0) begin
            st_d.shift = {st_q.shift[FW-2:0], 1'b0};
            st_d.bits  = st_q.bits - 1'b1;
        end else if (st_q.on) begin
            st_d.shift = '0;
            st_d.on    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o = st_q.shift[FW-1];
    assign on_o  = st_q.on;

    // R7: a report begins with the start bit in the cycle after it is taken
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> ser_o);
    // R7: a report is never cut short
    a_r7_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on && st_q.bits != '0) |=> st_q.on);
endmodule

// File: rtl/hit_group_readout.sv
module hit_group_readout #(
    parameter int NPIX = 256,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] hit_i,
    input  logic            frame_swap_i,
    output logic            ser_o,
    output logic            busy_o,
    output logic            overrun_o
);
    localparam int AW = $clog2(NPIX);

    typedef struct packed {
        logic [NPIX-1:0] hit;
        logic            swap;
        logic            bank_sel;
        logic [NPIX-1:0] mask;
        logic            overrun;
    } grp_t;

    grp_t st_d, st_q;

    logic [CW-1:0]   act_cnt [NPIX];
    logic [CW-1:0]   frz_cnt [NPIX];
    logic [NPIX-1:0] act_nz;
    logic [AW-1:0]   enc_idx;
    logic            enc_valid;
    logic            take;
    logic            ser_on;
    logic            swap_acc;
    logic [CW-1:0]   cnt_sel;

    assign busy_o   = ser_on || (|st_q.mask);
    assign swap_acc = st_q.swap && !busy_o;

    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        hgr_pixel #(.CW(CW)) u_pix (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (st_q.hit[i]),
            .swap_i    (swap_acc),
            .sel_i     (st_q.bank_sel),
            .act_cnt_o (act_cnt[i]),
            .frz_cnt_o (frz_cnt[i])
        );
        assign act_nz[i] = |act_cnt[i];
    end

    hgr_prio_enc #(.N(NPIX), .AW(AW)) u_enc (
        .req_i   (st_q.mask),
        .idx_o   (enc_idx),
        .valid_o (enc_valid)
    );

    assign cnt_sel = frz_cnt[enc_idx];

    hgr_serializer #(.AW(AW), .CW(CW)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .avail_i (enc_valid),
        .addr_i  (enc_idx),
        .cnt_i   (cnt_sel),
        .take_o  (take),
        .ser_o   (ser_o),
        .on_o    (ser_on)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hit  = hit_i;
        st_d.swap = frame_swap_i;
        if (swap_acc) begin
            st_d.bank_sel = ~st_q.bank_sel;
            st_d.mask     = act_nz;
        end else if (take) begin
            st_d.mask[enc_idx] = 1'b0;
        end
        if (st_q.swap && busy_o) st_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun_o = st_q.overrun;

    // R9: a refused swap leaves the bank selection alone
    a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.swap && busy_o) |=> $stable(st_q.bank_sel));
    // R9: the overrun flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
    // R5: every pixel handed to the serializer has a nonzero frozen count
    a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt_sel != '0);
    // R8: a swap is accepted only with an empty mask
    a_r8_idle_swap: assert property (@(posedge clk) disable iff (!rst_n)
        swap_acc |-> st_q.mask == '0);
endmodule

// File: tb/hit_group_readout_tb.sv
`timescale 1ns/1ps
module hit_group_readout_tb;
    localparam int NPIX = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIX-1:0] hit_i = '0;
    logic            frame_swap_i = 1'b0;
    logic            ser_o, busy_o, overrun_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int rx_addr [1024];
    int rx_cnt  [1024];
    int rx_n = 0;
    int exp_cnt [NPIX];

    always #2 clk = ~clk;

    hit_group_readout #(.NPIX(NPIX), .CW(5)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit_i),
        .frame_swap_i (frame_swap_i),
        .ser_o        (ser_o),
        .busy_o       (busy_o),
        .overrun_o    (overrun_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // serial line decoder, sampled on the falling edge
    int          bitpos = 0;
    logic [15:0] rsh = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bitpos == 0) begin
                if (ser_o) begin
                    rsh    = 16'd1;
                    bitpos = 1;
                end
            end else begin
                rsh    = {rsh[14:0], ser_o};
                bitpos = bitpos + 1;
                if (bitpos == 16) begin
                    chk(rsh[1:0] == 2'b00, "R7 stop bits", int'(rsh[1:0]), 0);
                    if (rx_n < 1024) begin
                        rx_addr[rx_n] = int'(rsh[14:7]);
                        rx_cnt[rx_n]  = int'(rsh[6:2]);
                    end
                    rx_n   = rx_n + 1;
                    bitpos = 0;
                end
            end
        end
    end

    task automatic drive(input logic [NPIX-1:0] v, input logic sw);
        @(negedge clk);
        hit_i        = v;
        frame_swap_i = sw;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // R5 R6 R3: compare received reports against the expected nonzero pixels
    task automatic compare(input string tag);
        int k = 0;
        for (int p = 0; p < NPIX; p++) begin
            if (exp_cnt[p] != 0) begin
                if (k < rx_n) begin
                    chk(rx_addr[k] == p, {tag, " R6 address order"}, rx_addr[k], p);
                    chk(rx_cnt[k] == exp_cnt[p], {tag, " R3 count"}, rx_cnt[k], exp_cnt[p]);
                end
                k++;
            end
        end
        chk(rx_n == k, {tag, " R5 report total"}, rx_n, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NPIX-1:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ser_o == 1'b0, "R10 ser idle", int'(ser_o), 0);
        chk(busy_o == 1'b0, "R10 busy", int'(busy_o), 0);
        chk(overrun_o == 1'b0, "R10 overrun", int'(overrun_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Frame A: pixel p gets p mod 37 hits (R2, R3)
        for (int k = 0; k < 37; k++) begin
            for (int p = 0; p < NPIX; p++) v[p] = (k < (p % 37));
            drive(v, 1'b0);
        end
        drive('0, 1'b0);
        for (int p = 0; p < NPIX; p++) exp_cnt[p] = ((p % 37) > 31) ? 31 : (p % 37);
        rx_n = 0;
        // R1 R4: a hit on pixel 5 coinciding with the swap goes to the new bank
        v = '0; v[5] = 1'b1;
        drive(v, 1'b1);
        drive('0, 1'b0);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b1, "R8 busy after swap", int'(busy_o), 1);

        // Frame B hits counted during readout of A (R2)
        for (int k = 0; k < 40; k++) begin
            v = '0;
            v[255] = 1'b1;
            v[0]   = (k < 3);
            v[128] = (k == 0);
            v[5]   = (k < 2);
            drive(v, 1'b0);
        end
        drive('0, 1'b0);
        chk(busy_o == 1'b1, "R8 busy during readout", int'(busy_o), 1);
        // R9: swap while busy is refused
        drive('0, 1'b1);
        drive('0, 1'b0);
        repeat (3) @(negedge clk);
        chk(overrun_o == 1'b1, "R9 overrun set", int'(overrun_o), 1);
        wait_idle();
        compare("frame A");

        // Frame B: sparse, extremes, saturation, coincident hit
        for (int p = 0; p < NPIX; p++) exp_cnt[p] = 0;
        exp_cnt[0] = 3; exp_cnt[5] = 3; exp_cnt[128] = 1; exp_cnt[255] = 31;
        rx_n = 0;
        drive('0, 1'b1);
        drive('0, 1'b0);
        wait_idle();
        compare("frame B R4 R9");

        // Frame C: empty, no output and busy stays low
        for (int p = 0; p < NPIX; p++) exp_cnt[p] = 0;
        rx_n = 0;
        drive('0, 1'b1);
        drive('0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R8 busy after empty swap", int'(busy_o), 0);
            chk(ser_o == 1'b0, "R7 line idle", int'(ser_o), 0);
        end
        compare("frame C");

        // Frame D: every pixel once, back-to-back reports
        drive('1, 1'b0);
        drive('0, 1'b0);
        for (int p = 0; p < NPIX; p++) exp_cnt[p] = 1;
        rx_n = 0;
        drive('0, 1'b1);
        drive('0, 1'b0);
        wait_idle();
        compare("frame D R7");
        chk(overrun_o == 1'b1, "R9 overrun sticky", int'(overrun_o), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule